// File: doc/BRIEF.md
# Multi-Source Reset Controller

This block gathers four reasons to reset a chip and turns them into one reset-active output for the machine-clock domain. The four reasons are a power-on event, an active-low external reset pin, a one-cycle software request strobe and a one-cycle watchdog overflow pulse. Each reason has its own rule for an oscillator stabilization wait. Power-on always waits a fixed, long count of oscillator cycles. A watchdog reset waits a length chosen by a 2-bit select field. The pin and software reasons release without a stabilization wait.

The pin is brought into the machine-clock domain through a synchronizer. It then passes a low-width filter, so short glitches are dropped. If the processor reports that a write instruction is in flight, a qualified pin reset is held back until the instruction-done flag is seen, so the write lands in full. String transfers are not announced as writes, so a pin reset can cut one short. Software and watchdog resets are never held back.

The stabilization counter runs on the oscillator clock. The start of a wait and its end cross between the two clocks as toggles through two-flop synchronizers, so the reset release is synchronous to the machine clock. A sticky cause register records which reason won. Software reads it and clears it with a strobe. There is no streaming data path, so every pin is a plain control or status signal with no valid/ready handshake.

Top module: `rst_merge_ctrl`

## Requirements
- R1: While `por_n` is low, and directly after it rises, `sys_rst` is 1 and `rst_cause` equals 4'b1000. Only the power-on bit is set.
- R2: A low pulse on `ext_rst_n` shorter than `MIN_LOW` machine cycles causes no reset and sets no cause bit.
- R3: When `ext_rst_n` stays low for at least `MIN_LOW` machine cycles, `sys_rst` asserts. It stays asserted while the pin remains low and releases a few machine cycles after the pin returns high, with no stabilization wait.
- R4: A one-cycle `sw_rst_req` asserts `sys_rst` at the next machine-clock edge. The release follows with no stabilization wait.
- R5: A `wd_ovf` pulse asserts `sys_rst` for at least 2^k oscillator cycles. k is taken from `wait_sel` when the pulse is accepted: 0→`WD_LOG2_0` (10), 1→`WD_LOG2_1` (13), 2→`WD_LOG2_2` (15), 3→`WD_LOG2_3` (17).
- R6: After `por_n` rises, `sys_rst` stays asserted for at least 2^`POR_LOG2` oscillator cycles (default 2^18).
- R7: A qualified pin reset is not accepted while `wr_busy` is 1 and `instr_done` is 0. It is accepted in a cycle where `instr_done` is 1 or `wr_busy` is 0.
- R8: Software and watchdog resets are accepted even while `wr_busy` is 1.
- R9: When several causes are ready in the same cycle, the pin wins over the watchdog, and the watchdog wins over software. Only the winner's cause bit is set.
- R10: `rst_cause` holds sticky bits: bit 0 software, bit 1 watchdog, bit 2 pin, bit 3 power-on. The bits are set only by an accepted reset and are all cleared by a one-cycle `flag_clr`.
- R11: Software or watchdog requests that arrive while `sys_rst` is asserted are ignored. They set no cause bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator clock; times the stabilization waits |
| mclk | input | 1 | Machine clock; the domain of all control inputs and outputs |
| por_n | input | 1 | Active-low power-on reset, asynchronous |
| ext_rst_n | input | 1 | Active-low external reset pin, asynchronous |
| sw_rst_req | input | 1 | One-cycle software reset request |
| wd_ovf | input | 1 | One-cycle watchdog overflow pulse |
| wait_sel | input | 2 | Selects the watchdog stabilization wait |
| wr_busy | input | 1 | A write instruction is executing |
| instr_done | input | 1 | The current instruction completes in this cycle |
| flag_clr | input | 1 | One-cycle clear of all cause bits |
| sys_rst | output | 1 | Reset-active output, released synchronously to `mclk` |
| rst_cause | output | 4 | Sticky cause bits {power-on, pin, watchdog, software} |

## Verification
Some properties are checked by the assertions on every cycle. A pin reset never starts while a write is open and incomplete. The latched cause stays one-hot and does not change during a reset. Cause bits only fall on a clear strobe. A pin reset never releases while the synchronized pin is low. The pending-pin flag only rises after the pin was seen low. The oscillator timer is never restarted while it is busy. Other behaviour needs the bench's scenarios. These are the length of each stabilization wait as the select field changes, the filter's cut-off between short and long pulses, the priority outcome when causes coincide, and the dropping of requests during an active reset.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
  localparam int NCAUSE = 4;
  localparam int CS_SW  = 0;
  localparam int CS_WD  = 1;
  localparam int CS_PIN = 2;
  localparam int CS_POR = 3;

  typedef logic [NCAUSE-1:0] cause_vec_t;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/rstc_sync2.sv
module rstc_sync2 #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/rstc_pin_filter.sv
module rstc_pin_filter #(
  parameter int MIN_LOW = 16
) (
  input  logic mclk,
  input  logic rst_n,
  input  logic pin_n,
  input  logic wr_busy,
  input  logic instr_done,
  input  logic take,
  output logic req,
  output logic pin_high
);
  localparam int CW = $clog2(MIN_LOW + 1);

  logic [CW-1:0] low_cnt;
  logic          pend_q;
  logic          hit;

  rstc_sync2 #(.RST_VAL(1'b1)) u_pin_sync (
    .clk  (mclk),
    .rst_n(rst_n),
    .d    (pin_n),
    .q    (pin_high)
  );

  assign hit = !pin_high && (low_cnt == CW'(MIN_LOW - 1));

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt <= '0;
      pend_q  <= 1'b0;
    end else begin
      if (pin_high)
        low_cnt <= '0;
      else if (low_cnt != CW'(MIN_LOW))
        low_cnt <= low_cnt + 1'b1;

      if (hit)
        pend_q <= 1'b1;
      else if (take)
        pend_q <= 1'b0;
    end
  end

  // an open write holds a qualified pin reset back
  assign req = pend_q && (!wr_busy || instr_done);

  // R2: the pending flag can only rise after the pin was seen low
  a_r2_pend_after_low: assert property (@(posedge mclk) disable iff (!rst_n)
    $rose(pend_q) |-> ($past(pin_high) == 1'b0));
endmodule

// File: rtl/rstc_wait_timer.sv
module rstc_wait_timer #(
  parameter int CW       = 18,
  parameter int POR_LOG2 = 18
) (
  input  logic          osc_clk,
  input  logic          rst_n,
  input  logic          start_tgl,
  input  logic [CW-1:0] len,
  output logic          done_tgl
);
  localparam logic [CW-1:0] POR_LEN = CW'((64'd1 << POR_LOG2) - 64'd1);

  logic          st_s, st_d;
  logic          busy_q;
  logic [CW-1:0] cnt_q;
  logic          start_edge;

  rstc_sync2 #(.RST_VAL(1'b0)) u_start_sync (
    .clk  (osc_clk),
    .rst_n(rst_n),
    .d    (start_tgl),
    .q    (st_s)
  );

  assign start_edge = st_s ^ st_d;

  // reset leaves the timer running the power-on wait
  always_ff @(posedge osc_clk or negedge rst_n) begin
    if (!rst_n) begin
      st_d     <= 1'b0;
      busy_q   <= 1'b1;
      cnt_q    <= POR_LEN;
      done_tgl <= 1'b0;
    end else begin
      st_d <= st_s;
      if (start_edge) begin
        busy_q <= 1'b1;
        cnt_q  <= len;
      end else if (busy_q) begin
        if (cnt_q == '0) begin
          busy_q   <= 1'b0;
          done_tgl <= ~done_tgl;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  // R5: a new wait is only requested once the previous one has ended
  a_r5_start_when_idle: assert property (@(posedge osc_clk) disable iff (!rst_n)
    start_edge |-> !busy_q);
endmodule

// File: rtl/rst_merge_ctrl.sv
module rst_merge_ctrl
  import rstc_pkg::*;
#(
  parameter int MIN_LOW   = 16,
  parameter int POR_LOG2  = 18,
  parameter int WD_LOG2_0 = 10,
  parameter int WD_LOG2_1 = 13,
  parameter int WD_LOG2_2 = 15,
  parameter int WD_LOG2_3 = 17
) (
  input  logic       osc_clk,
  input  logic       mclk,
  input  logic       por_n,
  input  logic       ext_rst_n,
  input  logic       sw_rst_req,
  input  logic       wd_ovf,
  input  logic [1:0] wait_sel,
  input  logic       wr_busy,
  input  logic       instr_done,
  input  logic       flag_clr,
  output logic       sys_rst,
  output logic [3:0] rst_cause
);
  localparam int CW = imax(imax(imax(WD_LOG2_0, WD_LOG2_1), imax(WD_LOG2_2, WD_LOG2_3)),
                           imax(POR_LOG2, 1));

  logic          pin_req, pin_high;
  logic          hold_q, start_q, done_s, done_d, done_seen_q;
  logic          done_tgl, done_edge, release_now;
  logic [CW-1:0] wlen_q, wd_len;
  cause_vec_t    cause_q, flags_q, pick;

  rstc_pin_filter #(.MIN_LOW(MIN_LOW)) u_pin (
    .mclk      (mclk),
    .rst_n     (por_n),
    .pin_n     (ext_rst_n),
    .wr_busy   (wr_busy),
    .instr_done(instr_done),
    .take      (pick[CS_PIN]),
    .req       (pin_req),
    .pin_high  (pin_high)
  );

  rstc_wait_timer #(.CW(CW), .POR_LOG2(POR_LOG2)) u_timer (
    .osc_clk  (osc_clk),
    .rst_n    (por_n),
    .start_tgl(start_q),
    .len      (wlen_q),
    .done_tgl (done_tgl)
  );

  rstc_sync2 #(.RST_VAL(1'b0)) u_done_sync (
    .clk  (mclk),
    .rst_n(por_n),
    .d    (done_tgl),
    .q    (done_s)
  );

  always_comb begin
    case (wait_sel)
      2'd0:    wd_len = CW'((64'd1 << WD_LOG2_0) - 64'd1);
      2'd1:    wd_len = CW'((64'd1 << WD_LOG2_1) - 64'd1);
      2'd2:    wd_len = CW'((64'd1 << WD_LOG2_2) - 64'd1);
      default: wd_len = CW'((64'd1 << WD_LOG2_3) - 64'd1);
    endcase
  end

  // fixed priority: pin, then watchdog, then software; nothing while in reset
  always_comb begin
    pick = '0;
    if (!hold_q) begin
      if (pin_req)         pick[CS_PIN] = 1'b1;
      else if (wd_ovf)     pick[CS_WD]  = 1'b1;
      else if (sw_rst_req) pick[CS_SW]  = 1'b1;
    end
  end

  assign done_edge   = done_s ^ done_d;
  assign release_now = hold_q && (done_seen_q || done_edge) &&
                       (!cause_q[CS_PIN] || pin_high);

  always_ff @(posedge mclk or negedge por_n) begin
    if (!por_n) begin
      hold_q      <= 1'b1;
      cause_q     <= cause_vec_t'(1) << CS_POR;
      flags_q     <= cause_vec_t'(1) << CS_POR;
      start_q     <= 1'b0;
      wlen_q      <= '0;
      done_d      <= 1'b0;
      done_seen_q <= 1'b0;
    end else begin
      done_d  <= done_s;
      flags_q <= (flag_clr ? '0 : flags_q) | pick;
      if (pick != '0) begin
        hold_q      <= 1'b1;
        cause_q     <= pick;
        wlen_q      <= pick[CS_WD] ? wd_len : '0;
        start_q     <= ~start_q;
        done_seen_q <= 1'b0;
      end else if (release_now) begin
        hold_q      <= 1'b0;
        done_seen_q <= 1'b0;
      end else if (hold_q && done_edge) begin
        done_seen_q <= 1'b1;
      end
    end
  end

  assign sys_rst   = hold_q;
  assign rst_cause = flags_q;

  // R7: a pin reset never begins while a write is open and not finishing
  a_r7_pin_waits_write: assert property (@(posedge mclk) disable iff (!por_n)
    ($rose(hold_q) && cause_q[CS_PIN]) |-> $past(!wr_busy || instr_done));

  // R9: exactly one cause is recorded for an active reset
  a_r9_cause_onehot: assert property (@(posedge mclk) disable iff (!por_n)
    hold_q |-> $onehot(cause_q));

  // R11: the recorded cause stays put while reset is held
  a_r11_cause_stable: assert property (@(posedge mclk) disable iff (!por_n)
    ($past(hold_q) && hold_q) |-> $stable(cause_q));

  // R10: cause bits only drop after a clear strobe
  a_r10_flags_sticky: assert property (@(posedge mclk) disable iff (!por_n)
    !$past(flag_clr) |-> ((flags_q & $past(flags_q)) == $past(flags_q)));

  // R3: a pin reset is not released while the pin is still low
  a_r3_release_pin_high: assert property (@(posedge mclk) disable iff (!por_n)
    ($fell(hold_q) && $past(cause_q[CS_PIN])) |-> $past(pin_high));
endmodule

// File: tb/rst_merge_ctrl_tb_top.sv
module rst_merge_ctrl_tb_top;
  localparam int MINL = 16;
  localparam int PORL = 8;
  localparam int W0 = 4, W1 = 5, W2 = 6, W3 = 7;

  logic osc_clk = 1'b0, mclk = 1'b0;
  logic por_n = 1'b0, ext_rst_n = 1'b1, sw_rst_req = 1'b0, wd_ovf = 1'b0;
  logic [1:0] wait_sel = 2'd0;
  logic wr_busy = 1'b0, instr_done = 1'b0, flag_clr = 1'b0;
  logic sys_rst;
  logic [3:0] rst_cause;
  int checks = 0, fails = 0;

  rst_merge_ctrl #(.MIN_LOW(MINL), .POR_LOG2(PORL), .WD_LOG2_0(W0),
                   .WD_LOG2_1(W1), .WD_LOG2_2(W2), .WD_LOG2_3(W3)) dut_i (
    .osc_clk(osc_clk), .mclk(mclk), .por_n(por_n), .ext_rst_n(ext_rst_n),
    .sw_rst_req(sw_rst_req), .wd_ovf(wd_ovf), .wait_sel(wait_sel),
    .wr_busy(wr_busy), .instr_done(instr_done), .flag_clr(flag_clr),
    .sys_rst(sys_rst), .rst_cause(rst_cause));

  always #5 osc_clk = ~osc_clk;
  initial begin
    #3;
    forever #10 mclk = ~mclk;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic mcyc(input int n);
    repeat (n) @(negedge mclk);
  endtask

  task automatic meas(output int n);
    n = 0;
    while (sys_rst === 1'b1 && n < 5000) begin
      @(posedge osc_clk);
      n++;
    end
  endtask

  task automatic clear_flags();
    @(negedge mclk) flag_clr = 1'b1;
    @(negedge mclk) flag_clr = 1'b0;
    chk(rst_cause == 4'b0000, "R10 clear", rst_cause, 0);
  endtask

  task automatic t_por();
    int n;
    mcyc(4);
    chk(sys_rst == 1'b1, "R1 reset held", sys_rst, 1);
    chk(rst_cause == 4'b1000, "R1 cause during por", rst_cause, 8);
    @(negedge mclk) por_n = 1'b1;
    meas(n);
    chk(n >= (1 << PORL) - 2 && n <= (1 << PORL) + 24, "R6 por wait", n, 1 << PORL);
    mcyc(2);
    chk(rst_cause == 4'b1000, "R1 cause after por", rst_cause, 8);
  endtask

  task automatic t_pin_short();
    @(negedge mclk) ext_rst_n = 1'b0;
    mcyc(MINL - 2);
    ext_rst_n = 1'b1;
    mcyc(10);
    chk(sys_rst == 1'b0, "R2 short pulse no reset", sys_rst, 0);
    chk(rst_cause == 4'b0000, "R2 short pulse no flag", rst_cause, 0);
  endtask

  task automatic t_pin_long();
    @(negedge mclk) ext_rst_n = 1'b0;
    mcyc(MINL + 8);
    chk(sys_rst == 1'b1, "R3 long pulse reset", sys_rst, 1);
    mcyc(16);
    chk(sys_rst == 1'b1, "R3 held while pin low", sys_rst, 1);
    ext_rst_n = 1'b1;
    mcyc(6);
    chk(sys_rst == 1'b0, "R3 release after pin high", sys_rst, 0);
    chk(rst_cause == 4'b0100, "R10 pin bit", rst_cause, 4);
    clear_flags();
  endtask

  task automatic t_sw();
    int n;
    @(negedge mclk) sw_rst_req = 1'b1;
    @(negedge mclk) sw_rst_req = 1'b0;
    chk(sys_rst == 1'b1, "R4 sw reset asserted", sys_rst, 1);
    meas(n);
    chk(n <= 16, "R4 sw no wait", n, 16);
    mcyc(2);
    chk(rst_cause == 4'b0001, "R10 sw bit", rst_cause, 1);
    clear_flags();
  endtask

  task automatic t_wd(input logic [1:0] sel, input int k);
    int n;
    wait_sel = sel;
    @(negedge mclk) wd_ovf = 1'b1;
    @(negedge mclk) wd_ovf = 1'b0;
    chk(sys_rst == 1'b1, "R5 wd reset asserted", sys_rst, 1);
    meas(n);
    chk(n >= (1 << k) - 4 && n <= (1 << k) + 24, "R5 wd wait", n, 1 << k);
    mcyc(2);
    chk(rst_cause == 4'b0010, "R10 wd bit", rst_cause, 2);
    clear_flags();
  endtask

  task automatic t_defer();
    @(negedge mclk) wr_busy = 1'b1;
    ext_rst_n = 1'b0;
    mcyc(MINL + 8);
    chk(sys_rst == 1'b0, "R7 deferred while write open", sys_rst, 0);
    ext_rst_n = 1'b1;
    mcyc(5);
    chk(sys_rst == 1'b0, "R7 still deferred", sys_rst, 0);
    instr_done = 1'b1;
    @(negedge mclk) instr_done = 1'b0;
    wr_busy = 1'b0;
    chk(sys_rst == 1'b1, "R7 taken at instr done", sys_rst, 1);
    mcyc(8);
    chk(sys_rst == 1'b0 && rst_cause == 4'b0100, "R7 released pin", rst_cause, 4);
    clear_flags();
  endtask

  task automatic t_nodefer();
    int n;
    @(negedge mclk) wr_busy = 1'b1;
    sw_rst_req = 1'b1;
    @(negedge mclk) sw_rst_req = 1'b0;
    chk(sys_rst == 1'b1, "R8 sw not deferred", sys_rst, 1);
    meas(n);
    mcyc(2);
    wait_sel = 2'd0;
    wd_ovf = 1'b1;
    @(negedge mclk) wd_ovf = 1'b0;
    chk(sys_rst == 1'b1, "R8 wd not deferred", sys_rst, 1);
    meas(n);
    mcyc(2);
    wr_busy = 1'b0;
    chk(rst_cause == 4'b0011, "R8 both flags", rst_cause, 3);
    clear_flags();
  endtask

  task automatic t_prio();
    int n;
    @(negedge mclk) wr_busy = 1'b1;
    ext_rst_n = 1'b0;
    mcyc(MINL + 8);
    ext_rst_n = 1'b1;
    mcyc(4);
    instr_done = 1'b1; wd_ovf = 1'b1; sw_rst_req = 1'b1;
    @(negedge mclk) instr_done = 1'b0; wd_ovf = 1'b0; sw_rst_req = 1'b0;
    wr_busy = 1'b0;
    meas(n);
    mcyc(3);
    chk(rst_cause == 4'b0100, "R9 pin wins", rst_cause, 4);
    clear_flags();
    wait_sel = 2'd0;
    @(negedge mclk) wd_ovf = 1'b1; sw_rst_req = 1'b1;
    @(negedge mclk) wd_ovf = 1'b0; sw_rst_req = 1'b0;
    meas(n);
    mcyc(3);
    chk(rst_cause == 4'b0010, "R9 wd beats sw", rst_cause, 2);
    clear_flags();
  endtask

  task automatic t_ignore();
    int n;
    wait_sel = 2'd3;
    @(negedge mclk) wd_ovf = 1'b1;
    @(negedge mclk) wd_ovf = 1'b0;
    mcyc(3);
    sw_rst_req = 1'b1;
    @(negedge mclk) sw_rst_req = 1'b0;
    mcyc(2);
    wd_ovf = 1'b1;
    @(negedge mclk) wd_ovf = 1'b0;
    meas(n);
    mcyc(3);
    chk(sys_rst == 1'b0, "R11 single release", sys_rst, 0);
    chk(rst_cause == 4'b0010, "R11 sw during reset ignored", rst_cause, 2);
    clear_flags();
  endtask

  initial begin
    repeat (150000) @(posedge osc_clk);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", checks + 1, fails);
    $finish;
  end

  initial begin
    t_por();
    clear_flags();
    t_pin_short();
    t_pin_long();
    t_sw();
    t_wd(2'd0, W0);
    t_wd(2'd1, W1);
    t_wd(2'd3, W3);
    t_defer();
    t_nodefer();
    t_prio();
    t_ignore();
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule